// File: doc/BRIEF.md
# Real-Time Seconds Counter with Alarm

This peripheral keeps wall-clock time as a 47-bit count of 32.768 kHz ticks. The low 15 bits are the fraction of a second and the upper 32 bits are whole seconds. Software reads and writes it through a small 32-bit register port. A single-cycle `tick` strobe, synchronous to `clk`, advances the counter by one while the run-enable field holds the value that means "on".

A 32-bit alarm register is compared against the whole-seconds part of the counter. When the alarm is armed and the seconds become equal to it, a sticky event is raised. The event stays set until software writes a 1 to its bit. A separate interrupt-enable field gates the event onto a level interrupt output.

To set the time, software stops the counter, writes both counter words and restarts the counter. Because the whole 47-bit count updates as one register, two consecutive reads of both words that agree on the seconds always give a consistent value.

Top module: `rtc_alarm`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: While stopped, writing offset 0x40 loads counter bits [31:0] and writing 0x44 loads bits [46:32] from write data bits [14:0]. Offset 0x44 reads the 15 high counter bits with bits [31:15] zero.
- R3: While the counter is running, writes to 0x40 and 0x44 leave the counter unchanged.
- R4: The counter adds exactly one per `tick` only when control bits [1:0] equal 2'b10. The codes 2'b00, 2'b01 and 2'b11 hold it.
- R5: A tick carries from bit 31 into bit 32 in the same cycle, and the all-ones count wraps to zero.
- R6: When control bits [3:2] equal 2'b10 and counter bits [46:15] become equal to the alarm register (offset 0x50, 32 bits, readable), the event register at 0x14 reads bit 3 set (field [3:2] = 2'b10) from the next cycle on.
- R7: With control bits [3:2] at any value other than 2'b10, a seconds match raises no event.
- R8: `irq` is high exactly when the alarm event is set and interrupt-enable bits [3:2] at offset 0x10 equal 2'b10.
- R9: The event stays set until a write to 0x14 with data bit 3 set. A write there with bit 3 clear leaves it set.
- R10: Writing 0x7A to 0x14 clears the event and drops `irq`.
- R11: Reads of unmapped offsets return zero, and control (0x08) keeps only bits [3:0].
- R12: While the seconds stay equal to the alarm, further ticks do not raise the event again after it has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 32.768 kHz advance strobe |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level alarm interrupt |

## Verification
The counter is loaded at fractions just below a second boundary and then ticked. This separates a correct seconds roll from an off-by-one, and with an all-ones low word it exposes any carry that lags into the high word. Each of the four enable codes is tried on both the run and alarm fields, so only 2'b10 can advance or arm. Repeated ticks inside an already matching second, after a clear, separate edge detection from level detection. Clears with data bit 3 low, high, and with 0x7A show whether the event is sticky and which bit clears it.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int FRAC_W = 15;
    localparam int CNT_W  = 47;

    // register byte offsets
    localparam int OFF_CTRL   = 'h08;
    localparam int OFF_IRQEN  = 'h10;
    localparam int OFF_EVT    = 'h14;
    localparam int OFF_CNT_LO = 'h40;
    localparam int OFF_CNT_HI = 'h44;
    localparam int OFF_ALARM  = 'h50;

    typedef enum logic [1:0] {
        EN_OFF = 2'b00,
        EN_DIS = 2'b01,
        EN_ON  = 2'b10,
        EN_RSV = 2'b11
    } en_code_e;

    typedef struct packed {
        logic [1:0] alarm;
        logic [1:0] run;
    } ctrl_t;

    typedef struct packed {
        logic ctrl;
        logic irqen;
        logic evt;
        logic cnt_lo;
        logic cnt_hi;
        logic alarm;
    } wsel_t;

    function automatic logic en_on(logic [1:0] code);
        return code == EN_ON;
    endfunction

endpackage

// File: rtl/rtc_regs.sv
module rtc_regs
    import rtc_alarm_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output wsel_t         wsel,
    output ctrl_t         ctrl_q,
    output logic [1:0]    irqen_q,
    output logic [SW-1:0] alarm_q
);

    always_comb begin
        wsel        = '0;
        wsel.ctrl   = we && (addr == AW'(OFF_CTRL));
        wsel.irqen  = we && (addr == AW'(OFF_IRQEN));
        wsel.evt    = we && (addr == AW'(OFF_EVT));
        wsel.cnt_lo = we && (addr == AW'(OFF_CNT_LO));
        wsel.cnt_hi = we && (addr == AW'(OFF_CNT_HI));
        wsel.alarm  = we && (addr == AW'(OFF_ALARM));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            irqen_q <= '0;
            alarm_q <= '0;
        end else begin
            if (wsel.ctrl)  ctrl_q  <= ctrl_t'(wdata[3:0]);
            if (wsel.irqen) irqen_q <= wdata[3:2];
            if (wsel.alarm) alarm_q <= wdata[SW-1:0];
        end
    end

endmodule

// File: rtl/rtc_count.sv
module rtc_count
    import rtc_alarm_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [DW-1:0] wdata,
    output logic [CW-1:0] cnt_q
);

    localparam int HI_W = CW - DW;

    logic [CW-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (run) begin
            if (tick) cnt_d = cnt_q + CW'(1);
        end else if (ld_lo) begin
            cnt_d[DW-1:0] = wdata;
        end else if (ld_hi) begin
            cnt_d[CW-1:DW] = wdata[HI_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

endmodule

// File: rtl/rtc_alarm_evt.sv
module rtc_alarm_evt #(
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          armed,
    input  logic [SW-1:0] secs,
    input  logic [SW-1:0] alarm,
    input  logic          clr,
    output logic          evt_q
);

    logic same_now;
    logic same_q;
    logic hit;

    assign same_now = (secs == alarm);
    assign hit      = armed && same_now && !same_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            same_q <= 1'b0;
            evt_q  <= 1'b0;
        end else begin
            same_q <= same_now;
            if (hit)      evt_q <= 1'b1;
            else if (clr) evt_q <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_alarm_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int CW = CNT_W,
    parameter int FW = FRAC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);

    localparam int SW = CW - FW;

    wsel_t         wsel;
    ctrl_t         ctrl_q;
    logic [1:0]    irqen_q;
    logic [SW-1:0] alarm_q;
    logic [CW-1:0] cnt_q;
    logic          evt_q;
    logic          run_on;
    logic          armed;
    logic          clr_evt;

    rtc_regs #(.AW(AW), .DW(DW), .SW(SW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .wsel    (wsel),
        .ctrl_q  (ctrl_q),
        .irqen_q (irqen_q),
        .alarm_q (alarm_q)
    );

    assign run_on  = en_on(ctrl_q.run);
    assign armed   = en_on(ctrl_q.alarm);
    assign clr_evt = wsel.evt && bus_wdata[3];

    rtc_count #(.CW(CW), .DW(DW)) u_count (
        .clk   (clk),
        .rst   (rst),
        .run   (run_on),
        .tick  (tick),
        .ld_lo (wsel.cnt_lo),
        .ld_hi (wsel.cnt_hi),
        .wdata (bus_wdata),
        .cnt_q (cnt_q)
    );

    rtc_alarm_evt #(.SW(SW)) u_evt (
        .clk   (clk),
        .rst   (rst),
        .armed (armed),
        .secs  (cnt_q[CW-1:FW]),
        .alarm (alarm_q),
        .clr   (clr_evt),
        .evt_q (evt_q)
    );

    assign irq = evt_q && en_on(irqen_q);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(OFF_CTRL):   bus_rdata = DW'(ctrl_q);
            AW'(OFF_IRQEN):  bus_rdata = DW'({irqen_q, 2'b00});
            AW'(OFF_EVT):    bus_rdata = DW'({evt_q, 3'b000});
            AW'(OFF_CNT_LO): bus_rdata = cnt_q[DW-1:0];
            AW'(OFF_CNT_HI): bus_rdata = DW'(cnt_q[CW-1:DW]);
            AW'(OFF_ALARM):  bus_rdata = DW'(alarm_q);
            default:         bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk #(
    parameter int CW = 47
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          run,
    input logic          wr_cnt,
    input logic          armed,
    input logic          clr_evt,
    input logic          evt,
    input logic [CW-1:0] cnt
);

    assert_frozen_running_R3: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(cnt));

    assert_hold_stopped_R4: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_cnt) |=> $stable(cnt));

    assert_step_one_R5: assert property (@(posedge clk) disable iff (rst)
        (run && tick) |=> (cnt == $past(cnt) + CW'(1)));

    assert_event_needs_arm_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(evt) |-> $past(armed));

    assert_event_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (evt && !clr_evt) |=> evt);

endmodule

bind rtc_alarm rtc_alarm_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .run     (run_on),
    .wr_cnt  (wsel.cnt_lo || wsel.cnt_hi),
    .armed   (armed),
    .clr_evt (clr_evt),
    .evt     (evt_q),
    .cnt     (cnt_q)
);

// File: tb/sim_rtc_alarm.sv
`timescale 1ns/1ps
module sim_rtc_alarm;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tb_tick = 1'b0;
    logic        tb_we = 1'b0;
    logic [7:0]  tb_addr = '0;
    logic [31:0] tb_wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    rtc_alarm u0 (
        .clk       (clk),
        .rst       (rst),
        .tick      (tb_tick),
        .bus_we    (tb_we),
        .bus_addr  (tb_addr),
        .bus_wdata (tb_wdata),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    // behavioural reference
    logic [46:0] m_cnt;
    logic [3:0]  m_ctrl;
    logic [1:0]  m_ie;
    logic        m_evt;
    logic        m_prev;
    logic [31:0] m_alarm;

    always @(posedge clk) begin
        bit run;
        bit same;
        if (rst) begin
            m_cnt = '0; m_ctrl = '0; m_ie = '0; m_evt = 0; m_prev = 0; m_alarm = '0;
        end else begin
            run  = (m_ctrl[1:0] == 2'b10);
            same = (m_cnt[46:15] == m_alarm);
            if (m_ctrl[3:2] == 2'b10 && same && !m_prev) m_evt = 1;
            else if (tb_we && tb_addr == 8'h14 && tb_wdata[3]) m_evt = 0;
            m_prev = same;
            if (run) begin
                if (tb_tick) m_cnt = m_cnt + 47'd1;
            end else if (tb_we && tb_addr == 8'h40) m_cnt[31:0] = tb_wdata;
            else if (tb_we && tb_addr == 8'h44) m_cnt[46:32] = tb_wdata[14:0];
            if (tb_we && tb_addr == 8'h08) m_ctrl = tb_wdata[3:0];
            if (tb_we && tb_addr == 8'h10) m_ie = tb_wdata[3:2];
            if (tb_we && tb_addr == 8'h50) m_alarm = tb_wdata;
        end
    end

    function automatic logic [31:0] m_read(logic [7:0] a);
        case (a)
            8'h08:   return {28'd0, m_ctrl};
            8'h10:   return {28'd0, m_ie, 2'b00};
            8'h14:   return {28'd0, m_evt, 3'b000};
            8'h40:   return m_cnt[31:0];
            8'h44:   return {17'd0, m_cnt[46:32]};
            8'h50:   return m_alarm;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] a);
        case (a)
            8'h08:        return "R11";
            8'h10:        return "R8";
            8'h14:        return "R9";
            8'h40, 8'h44: return "R4";
            8'h50:        return "R6";
            default:      return "R11";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(tag_of(tb_addr), rdata, m_read(tb_addr));
            chk("R8", {31'd0, irq}, {31'd0, m_evt && (m_ie == 2'b10)});
        end
    end

    task automatic cyc(bit we, logic [7:0] a, logic [31:0] d, bit t);
        @(negedge clk);
        #2;
        tb_we = we; tb_addr = a; tb_wdata = d; tb_tick = t;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        cyc(1, a, d, 0);
    endtask

    task automatic tk(int n);
        for (int i = 0; i < n; i++) cyc(0, 8'h00, 32'd0, 1);
        cyc(0, 8'h00, 32'd0, 0);
    endtask

    task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
        cyc(0, a, 32'd0, 0);
        #4;
        chk(tag, rdata, exp);
    endtask

    task automatic irq_is(string tag, bit exp);
        cyc(0, 8'h00, 32'd0, 0);
        #4;
        chk(tag, {31'd0, irq}, {31'd0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); #2; rst = 0;

        // R1 reset state
        rd("R1", 8'h08, 0); rd("R1", 8'h10, 0); rd("R1", 8'h14, 0);
        rd("R1", 8'h40, 0); rd("R1", 8'h44, 0); rd("R1", 8'h50, 0);
        irq_is("R1", 0);

        // R2 load while stopped
        wr(8'h40, 32'h0003_7FFE);
        wr(8'h44, 32'h0001_2345);
        rd("R2", 8'h40, 32'h0003_7FFE);
        rd("R2", 8'h44, 32'h0000_2345);

        // R4 only code 2'b10 runs
        wr(8'h08, 32'h1); tk(3); rd("R4", 8'h40, 32'h0003_7FFE);
        wr(8'h08, 32'h3); tk(3); rd("R4", 8'h40, 32'h0003_7FFE);
        wr(8'h08, 32'h2); tk(1); rd("R4", 8'h40, 32'h0003_7FFF);

        // R3 writes ignored while running
        wr(8'h40, 32'h0); wr(8'h44, 32'h0);
        rd("R3", 8'h40, 32'h0003_7FFF);
        rd("R3", 8'h44, 32'h0000_2345);

        // R5 carry and wrap
        wr(8'h08, 32'h0);
        wr(8'h40, 32'hFFFF_FFFF); wr(8'h44, 32'h5);
        wr(8'h08, 32'h2); tk(1);
        rd("R5", 8'h40, 32'h0); rd("R5", 8'h44, 32'h6);
        wr(8'h08, 32'h0);
        wr(8'h40, 32'hFFFF_FFFF); wr(8'h44, 32'h7FFF);
        wr(8'h08, 32'h2); tk(1);
        rd("R5", 8'h40, 32'h0); rd("R5", 8'h44, 32'h0);

        // R6 alarm match edge, R8 interrupt
        wr(8'h08, 32'h0);
        wr(8'h40, 32'h0004_FFFE); wr(8'h44, 32'h0);
        wr(8'h50, 32'd10); wr(8'h10, 32'h8); wr(8'h08, 32'hA);
        rd("R6", 8'h50, 32'd10);
        tk(1); cyc(0, 8'h00, 0, 0);
        rd("R6", 8'h14, 32'h0); irq_is("R8", 0);
        tk(1); cyc(0, 8'h00, 0, 0);
        rd("R6", 8'h14, 32'h8); irq_is("R8", 1);

        // R9 sticky, bit 3 clears
        wr(8'h14, 32'h4); rd("R9", 8'h14, 32'h8);
        wr(8'h14, 32'h8); rd("R9", 8'h14, 32'h0);

        // R12 no re-raise while still equal
        tk(3); cyc(0, 8'h00, 0, 0);
        rd("R12", 8'h14, 32'h0); irq_is("R12", 0);

        // R8 masking codes
        wr(8'h08, 32'h8);
        wr(8'h40, 32'h0005_7FFF); wr(8'h44, 32'h0);
        wr(8'h50, 32'd11); wr(8'h08, 32'hA); wr(8'h10, 32'h4);
        tk(1); cyc(0, 8'h00, 0, 0);
        rd("R6", 8'h14, 32'h8); irq_is("R8", 0);
        wr(8'h10, 32'h8); irq_is("R8", 1);
        wr(8'h10, 32'hC); irq_is("R8", 0);
        wr(8'h10, 32'h8); irq_is("R8", 1);

        // R10 bulk clear
        wr(8'h14, 32'h7A); rd("R10", 8'h14, 32'h0); irq_is("R10", 0);

        // R7 disarmed alarm
        wr(8'h08, 32'h4);
        wr(8'h40, 32'h0005_FFFF); wr(8'h44, 32'h0);
        wr(8'h50, 32'd12); wr(8'h08, 32'h6);
        tk(1); cyc(0, 8'h00, 0, 0);
        rd("R7", 8'h14, 32'h0); rd("R4", 8'h40, 32'h0006_0000);
        wr(8'h08, 32'h0);
        wr(8'h40, 32'h0006_7FFF);
        wr(8'h50, 32'd13); wr(8'h08, 32'hE);
        tk(1); cyc(0, 8'h00, 0, 0);
        rd("R7", 8'h14, 32'h0);

        // R11 unmapped and unimplemented bits
        rd("R11", 8'h0C, 0); rd("R11", 8'h48, 0); rd("R11", 8'h54, 0);
        wr(8'h08, 32'hFFFF_FFF0); rd("R11", 8'h08, 0);

        cyc(0, 8'h00, 0, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule